// File: doc/BRIEF.md
# Multi-Sensor Over-Temperature Monitor

This block watches four digitised temperatures inside a power converter: the air at the inlet, the output isolation switch, the air at the outlet, and the heat sink of the auxiliary (standby) converter stage. Every reading is an unsigned fixed-point count in steps of 0.5 °C. All four readings come in together on one parallel bus, and a single valid strobe qualifies them. Each sensor has its own warning level and its own shutdown level, both set by parameters.

A warning on any sensor drives the fan to full speed. The active-low alert line to the system follows later, and it never goes low before the fan request is already up. Each shutdown event is latched against the rail its sensor belongs to. A parameter mask names the sensors that guard the standby converter. All other sensors guard the main rail. A latched shutdown stays set until an external clear strobe arrives. A warning clears by itself once the reading falls 2 °C below its level.

Top module: `thermal_guard`

## Requirements
- R1: While reset is high and in the first cycle after it, fan_max_o, warn_o, shut_main_o and shut_sby_o are 0 and alert_n_o is 1.
- R2: A valid reading at or above a sensor's warning level sets that sensor's warning at the clock edge that samples the strobe. The default warning levels are 125 (inlet, 62.5 °C), 220 (switch), 150 (outlet) and 200 (auxiliary sink). warn_o rises at the next edge.
- R3: A warning stays set while valid readings sit between the clear level and the warning level. The clear level is the warning level minus 4 counts (2 °C). A valid reading at or below the clear level clears the warning.
- R4: While valid_i is 0, the readings and thresholds have no effect on any warning or shutdown state.
- R5: fan_max_o is 1 exactly one edge after any warning or shutdown latch is set, and it falls one edge after all of them are clear.
- R6: alert_n_o goes low one edge after fan_max_o rises. It is never low while fan_max_o is low. It goes high on the same edge fan_max_o falls.
- R7: A valid reading at or above the shutdown level of a main-rail sensor latches shut_main_o at the sampling edge. The default shutdown levels are 140, 250, 170 and 230, in sensor order 0..3. Sensors 0 to 2 are main-rail sensors by default.
- R8: A shutdown on a standby-mapped sensor (default: sensor 3, the auxiliary sink) latches shut_sby_o only.
- R9: Shutdown latches hold until clr_i. A clear at an edge with no new hit on that rail drops the latch. A new hit at the same edge keeps it set.
- R10: clr_i has no effect on warnings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Strobe qualifying temps_i |
| temps_i | input | NSENS*TW | Readings, sensor 0 in the low TW bits, 0.5 °C per count |
| clr_i | input | 1 | Clears latched shutdowns |
| fan_max_o | output | 1 | Request to run the fan at full speed |
| warn_o | output | 1 | Any sensor is in warning |
| shut_main_o | output | 1 | Main rail shutdown request (latched) |
| shut_sby_o | output | 1 | Standby rail shutdown request (latched) |
| alert_n_o | output | 1 | Active-low system alert |

## Verification
A stuck or wrongly updated warning flag shows up on warn_o and fan_max_o one edge after the strobe that should have changed it, and on alert_n_o one edge after that. A shutdown latch that is mis-set, mis-routed or cleared too early shows up on shut_main_o or shut_sby_o right after the sampling edge, and a fault hidden there stays visible until the next clear. The bench therefore compares every output every cycle against a bench-side model. This catches any divergence within two edges of its cause.

// File: rtl/thermal_guard_pkg.sv
package thermal_guard_pkg;
  typedef enum int unsigned {
    SNS_INLET  = 0,
    SNS_SWITCH = 1,
    SNS_OUTLET = 2,
    SNS_AUXHS  = 3
  } sensor_id_e;

  localparam int unsigned DEF_NSENS = 4;
  localparam int unsigned DEF_TW    = 10;
  localparam int unsigned DEF_HYST  = 4;  // 2 degC at 0.5 degC per count
endpackage

// File: rtl/thermal_guard_cmp.sv
module thermal_guard_cmp #(
  parameter int unsigned TW   = 10,
  parameter int unsigned WARN = 125,
  parameter int unsigned SHUT = 140,
  parameter int unsigned HYST = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_i,
  input  logic [TW-1:0] temp_i,
  output logic          warn_o,
  output logic          shut_hit_o
);
  localparam logic [TW-1:0] WARN_L = TW'(WARN);
  localparam logic [TW-1:0] SHUT_L = TW'(SHUT);
  localparam logic [TW-1:0] CLR_L  = (WARN >= HYST) ? TW'(WARN - HYST) : '0;

  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (valid_i) begin
      if (temp_i >= WARN_L)     flag_q <= 1'b1;
      else if (temp_i <= CLR_L) flag_q <= 1'b0;
    end
  end

  assign warn_o     = flag_q;
  assign shut_hit_o = valid_i && (temp_i >= SHUT_L);

  assert_warn_set_R2: assert property (@(posedge clk) disable iff (rst)
    (valid_i && temp_i >= WARN_L) |=> warn_o);
  assert_band_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (valid_i && warn_o && temp_i > CLR_L && temp_i < WARN_L) |=> warn_o);
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(warn_o));
endmodule

// File: rtl/thermal_guard_rail.sv
module thermal_guard_rail #(
  parameter int unsigned       NSENS    = 4,
  parameter logic [NSENS-1:0]  STBY_MAP = 4'b1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSENS-1:0] hit_i,
  input  logic             clr_i,
  output logic             shut_main_o,
  output logic             shut_sby_o
);
  logic hit_main, hit_sby;
  logic main_q, sby_q;

  assign hit_main = |(hit_i & ~STBY_MAP);
  assign hit_sby  = |(hit_i & STBY_MAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      main_q <= 1'b0;
      sby_q  <= 1'b0;
    end else begin
      main_q <= hit_main | (main_q & ~clr_i);
      sby_q  <= hit_sby  | (sby_q  & ~clr_i);
    end
  end

  assign shut_main_o = main_q;
  assign shut_sby_o  = sby_q;

  assert_main_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (shut_main_o && !clr_i) |=> shut_main_o);
  assert_main_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !hit_main) |=> !shut_main_o);
  assert_sby_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (shut_sby_o && !clr_i) |=> shut_sby_o);
endmodule

// File: rtl/thermal_guard_seq.sv
module thermal_guard_seq #(
  parameter int unsigned NSENS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSENS-1:0] warn_vec_i,
  input  logic             shut_main_i,
  input  logic             shut_sby_i,
  output logic             fan_max_o,
  output logic             warn_o,
  output logic             alert_n_o
);
  logic any_evt;
  logic fan_q, warn_q, alert_n_q;

  assign any_evt = (|warn_vec_i) | shut_main_i | shut_sby_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      fan_q     <= 1'b0;
      warn_q    <= 1'b0;
      alert_n_q <= 1'b1;
    end else begin
      fan_q     <= any_evt;
      warn_q    <= |warn_vec_i;
      alert_n_q <= ~(any_evt & fan_q);
    end
  end

  assign fan_max_o = fan_q;
  assign warn_o    = warn_q;
  assign alert_n_o = alert_n_q;

  assert_fan_follows_R5: assert property (@(posedge clk) disable iff (rst)
    any_evt |=> fan_max_o);
  assert_alert_needs_fan_R6: assert property (@(posedge clk) disable iff (rst)
    !alert_n_o |-> fan_max_o);
  assert_alert_after_fan_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(alert_n_o) |-> $past(fan_max_o));
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
  import thermal_guard_pkg::*;
#(
  parameter int unsigned            NSENS    = DEF_NSENS,
  parameter int unsigned            TW       = DEF_TW,
  parameter int unsigned            HYST     = DEF_HYST,
  parameter logic [NSENS*TW-1:0]    WARN_THR = {10'd200, 10'd150, 10'd220, 10'd125},
  parameter logic [NSENS*TW-1:0]    SHUT_THR = {10'd230, 10'd170, 10'd250, 10'd140},
  parameter logic [NSENS-1:0]       STBY_MAP = NSENS'(1) << SNS_AUXHS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid_i,
  input  logic [NSENS*TW-1:0] temps_i,
  input  logic                clr_i,
  output logic                fan_max_o,
  output logic                warn_o,
  output logic                shut_main_o,
  output logic                shut_sby_o,
  output logic                alert_n_o
);
  logic [NSENS-1:0] warn_vec;
  logic [NSENS-1:0] hit_vec;

  for (genvar g = 0; g < NSENS; g++) begin : g_sens
    thermal_guard_cmp #(
      .TW  (TW),
      .WARN(int'(WARN_THR[g*TW +: TW])),
      .SHUT(int'(SHUT_THR[g*TW +: TW])),
      .HYST(HYST)
    ) u_cmp (
      .clk       (clk),
      .rst       (rst),
      .valid_i   (valid_i),
      .temp_i    (temps_i[g*TW +: TW]),
      .warn_o    (warn_vec[g]),
      .shut_hit_o(hit_vec[g])
    );
  end

  thermal_guard_rail #(.NSENS(NSENS), .STBY_MAP(STBY_MAP)) u_rail (
    .clk        (clk),
    .rst        (rst),
    .hit_i      (hit_vec),
    .clr_i      (clr_i),
    .shut_main_o(shut_main_o),
    .shut_sby_o (shut_sby_o)
  );

  thermal_guard_seq #(.NSENS(NSENS)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .warn_vec_i (warn_vec),
    .shut_main_i(shut_main_o),
    .shut_sby_i (shut_sby_o),
    .fan_max_o  (fan_max_o),
    .warn_o     (warn_o),
    .alert_n_o  (alert_n_o)
  );

  assert_warn_clr_indep_R10: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !valid_i) |=> $stable(warn_vec));
endmodule

// File: tb/sim_thermal_guard.sv
module sim_thermal_guard;
  localparam int TW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic valid_i = 1'b0;
  logic [4*TW-1:0] temps_i = '0;
  logic clr_i = 1'b0;
  logic fan_max_o, warn_o, shut_main_o, shut_sby_o, alert_n_o;

  int checks = 0;
  int failures = 0;

  int unsigned bw [4] = '{125, 220, 150, 200};
  int unsigned bs [4] = '{140, 250, 170, 230};

  logic m_wf [4];
  logic m_sm, m_ss, m_fan, m_warn, m_alert_n;

  thermal_guard u0 (
    .clk(clk), .rst(rst), .valid_i(valid_i), .temps_i(temps_i), .clr_i(clr_i),
    .fan_max_o(fan_max_o), .warn_o(warn_o), .shut_main_o(shut_main_o),
    .shut_sby_o(shut_sby_o), .alert_n_o(alert_n_o)
  );

  always #2 clk = ~clk;

  function automatic logic [4*TW-1:0] pk(input int a, input int b, input int c, input int d);
    return {TW'(d), TW'(c), TW'(b), TW'(a)};
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) m_wf[i] = 1'b0;
    m_sm = 0; m_ss = 0; m_fan = 0; m_warn = 0; m_alert_n = 1;
  endtask

  task automatic model_edge(input logic v, input logic [4*TW-1:0] t, input logic c);
    logic any_old, wany, hm, hs;
    int unsigned r;
    wany = 0;
    for (int i = 0; i < 4; i++) wany |= m_wf[i];
    any_old = wany | m_sm | m_ss;
    m_alert_n = !(any_old && m_fan);
    m_fan = any_old;
    m_warn = wany;
    hm = 0; hs = 0;
    for (int i = 0; i < 4; i++) begin
      r = int'(t[i*TW +: TW]);
      if (v) begin
        if (r >= bw[i]) m_wf[i] = 1'b1;
        else if (r + 4 <= bw[i]) m_wf[i] = 1'b0;
        if (r >= bs[i]) begin
          if (i == 3) hs = 1; else hm = 1;
        end
      end
    end
    m_sm = hm | (m_sm & !c);
    m_ss = hs | (m_ss & !c);
  endtask

  task automatic compare_all();
    chk("R2 warn", warn_o, m_warn);
    chk("R5 fan_max", fan_max_o, m_fan);
    chk("R6 alert_n", alert_n_o, m_alert_n);
    chk("R7 shut_main", shut_main_o, m_sm);
    chk("R8 shut_sby", shut_sby_o, m_ss);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic v, input logic [4*TW-1:0] t, input logic c);
    valid_i = v; temps_i = t; clr_i = c;
    @(posedge clk);
    model_edge(v, t, c);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 fan", fan_max_o, 1'b0);
    chk("R1 warn", warn_o, 1'b0);
    chk("R1 shut_main", shut_main_o, 1'b0);
    chk("R1 shut_sby", shut_sby_o, 1'b0);
    chk("R1 alert_n", alert_n_o, 1'b1);
    rst = 1'b0;
    step(0, '0, 0);
    chk("R1 idle alert_n", alert_n_o, 1'b1);

    // R2: inlet exactly at 62.5 degC
    step(1, pk(125, 0, 0, 0), 0);
    chk("R2 warn not yet", warn_o, 1'b0);
    step(0, '0, 0);
    chk("R2 warn set", warn_o, 1'b1);
    chk("R5 fan set", fan_max_o, 1'b1);
    chk("R6 alert still high", alert_n_o, 1'b1);
    step(0, '0, 0);
    chk("R6 alert low", alert_n_o, 1'b0);
    // R4: invalid low readings ignored
    step(0, pk(0, 0, 0, 0), 0);
    step(0, '0, 0);
    chk("R4 warn held", warn_o, 1'b1);
    // R3: in band keeps, clear level clears
    step(1, pk(122, 0, 0, 0), 0);
    step(0, '0, 0);
    chk("R3 band hold", warn_o, 1'b1);
    step(1, pk(121, 0, 0, 0), 0);
    step(0, '0, 0);
    chk("R3 cleared", warn_o, 1'b0);
    chk("R6 alert released with fan", alert_n_o, fan_max_o ? 1'b0 : 1'b1);
    step(0, '0, 0);
    // R7: outlet shutdown
    step(1, pk(0, 0, 170, 0), 0);
    chk("R7 main latched", shut_main_o, 1'b1);
    chk("R8 sby untouched", shut_sby_o, 1'b0);
    // R8: auxiliary sink shutdown
    step(1, pk(0, 0, 0, 230), 0);
    chk("R8 sby latched", shut_sby_o, 1'b1);
    repeat (3) step(1, pk(0, 0, 0, 0), 0);
    chk("R9 main held", shut_main_o, 1'b1);
    // R10: warning survives clear; R9 clear
    step(1, pk(0, 0, 150, 0), 0);
    step(0, '0, 1);
    chk("R9 main cleared", shut_main_o, 1'b0);
    chk("R9 sby cleared", shut_sby_o, 1'b0);
    step(0, '0, 1);
    chk("R10 warn after clear", warn_o, 1'b1);
    // R9: clear with concurrent hit keeps set
    step(1, pk(140, 0, 0, 0), 1);
    chk("R9 hit beats clear", shut_main_o, 1'b1);
    step(1, '0, 1);

    // random phase, model compared every cycle
    for (int n = 0; n < 4000; n++) begin
      logic v, c;
      v = ($urandom_range(0, 3) != 0);
      c = ($urandom_range(0, 7) == 0);
      step(v, pk($urandom_range(100, 160), $urandom_range(200, 260),
                 $urandom_range(130, 180), $urandom_range(180, 240)), c);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule